// File: doc/BRIEF.md
# Two-Sample Cycle Adjustment Engine

This block measures the change in a sampled error signal across one switching period and turns it into a signed correction for PWM duty cycles. One PWM A output is picked as the period marker. A measurement starts on that output's rising edge. The block then takes one error sample from a chosen front end and, in a later cycle, a second sample from another chosen front end (which may be the same one). The difference between the two samples, second minus first, is shifted left by a programmable gain and saturated. It is then clamped between a programmable floor and ceiling and published as the adjustment word.

Each PWM channel has its own opt-in bit. Opted-in channels add the published adjustment to their nominal duty, with the result saturated to the duty range. All other channels pass the nominal duty through unchanged.

The input error is scaled at 1 mV per LSB. The output is scaled at one 4 ns PWM step per LSB, so with gain 0 a one-LSB difference gives exactly one step. Three small registers are written through a plain write strobe: a control word, a ceiling and a floor.

Top module: `cyc_adj_top`

## Requirements
- R1: After reset the following values hold:
  - the enable bit, gain and all three selects are 0;
  - the ceiling is the largest signed ADJ_W value and the floor is the smallest;
  - `adj_out` is 0 and `adj_done` is 0.
- R2: A write with `reg_we`=1 takes effect from the next cycle. The address selects the target:
  - address 0 is the control word: bit 0 enable, bits 3:1 gain, bits 5:4 sync select, bits 7:6 first-sample select, bits 9:8 second-sample select (default widths);
  - address 1 is the ceiling and address 2 is the floor, each as a signed ADJ_W value;
  - address 3 changes nothing.
- R3: A measurement starts only on a 0-to-1 transition of the `pwm_a` bit chosen by the sync select. Edges on other bits are ignored. The edge detector's previous value resets to 0.
- R4: After the start edge, the first `fe_valid` strobe from the first-selected front end captures that front end's error. Strobes from other front ends are ignored, and so is a strobe in the same cycle as the start edge.
- R5: The second sample is the first later-cycle strobe from the second-selected front end. When both selects name the same front end, one strobe counts only as the first sample.
- R6: The raw result is (second − first) arithmetically shifted left by the gain (0..7) and saturated to signed ADJ_W. With gain 0, a difference of 1 gives an adjustment of 1.
- R7: The saturated result is first limited to at most the ceiling, and then raised to at least the floor. The floor therefore wins when the floor is above the ceiling.
- R8: The edge that samples the second strobe updates `adj_out` and raises `adj_done` for exactly one cycle. `adj_out` then holds until the next completed measurement.
- R9: A selected start edge while waiting for either sample abandons the partial measurement. The published value is kept, and the block waits for a new first sample.
- R10: While the enable bit is 0, `adj_out` is 0, `adj_done` is 0 and no measurement progresses. After enable is set again, `adj_out` stays 0 until a new measurement completes.
- R11: `duty_out` for a channel with its `duty_adj_en` bit set is `duty_nom` + `adj_out`, saturated to 0..2^DUTY_W−1. A channel with the bit clear outputs `duty_nom` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 ceiling, 2 floor |
| reg_wdata | input | REG_W | Write data |
| pwm_a | input | N_PWM | PWM A output levels |
| fe_valid | input | N_FE | Per-front-end sample strobes |
| fe_err | input | N_FE*ERR_W | Packed signed error values, front end k at bits k*ERR_W upward |
| duty_nom | input | N_PWM*DUTY_W | Packed nominal duty per channel |
| duty_adj_en | input | N_PWM | Per-channel adjust opt-in |
| adj_out | output | ADJ_W | Published signed adjustment |
| adj_done | output | 1 | One-cycle pulse on each update |
| duty_out | output | N_PWM*DUTY_W | Packed adjusted duty per channel |

## Verification
The bench targets the following corner cases:
- **Ignored strobes.** Edges on unselected PWM outputs, and strobes from unselected front ends, must not start a measurement or supply a sample. A design that reacted to them would publish values from the wrong samples.
- **Same front end for both samples.** With both selects on one front end, a design that accepted a single strobe as both samples would publish zero instead of the real difference.
- **Re-sync.** A start edge in the middle of a measurement must discard the stale first sample. Keeping it would skew the next result.
- **Gain and limit extremes.** The bench drives large gains into saturation and programs a floor above the ceiling. Wraparound, or clamping in the wrong order, shows up as a wrong sign or a wrong value.
- **Duty saturation.** Duty values near both ends of the range must stick at the limits instead of wrapping.
- **Disable.** Clearing enable mid-measurement must give a zero output and no stray done pulse.

// File: rtl/cadj_pkg.sv
package cadj_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT1 = 2'd1,
    SEQ_WAIT2 = 2'd2
  } seq_state_e;

  localparam int GAIN_W  = 3;
  localparam int MAX_SHIFT = 7;
endpackage

// File: rtl/cadj_regs.sv
module cadj_regs #(
  parameter int SYNC_W = 2,
  parameter int SEL_W  = 2,
  parameter int ADJ_W  = 12,
  parameter int REG_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [1:0]              addr,
  input  logic [REG_W-1:0]        wdata,
  output logic                    en,
  output logic [cadj_pkg::GAIN_W-1:0] gain,
  output logic [SYNC_W-1:0]       sync_sel,
  output logic [SEL_W-1:0]        first_sel,
  output logic [SEL_W-1:0]        second_sel,
  output logic signed [ADJ_W-1:0] lim_hi,
  output logic signed [ADJ_W-1:0] lim_lo
);
  localparam int OFF_GAIN   = 1;
  localparam int OFF_SYNC   = OFF_GAIN + cadj_pkg::GAIN_W;
  localparam int OFF_FIRST  = OFF_SYNC + SYNC_W;
  localparam int OFF_SECOND = OFF_FIRST + SEL_W;
  localparam logic signed [ADJ_W-1:0] HI_RST = {1'b0, {(ADJ_W-1){1'b1}}};
  localparam logic signed [ADJ_W-1:0] LO_RST = {1'b1, {(ADJ_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en         <= 1'b0;
      gain       <= '0;
      sync_sel   <= '0;
      first_sel  <= '0;
      second_sel <= '0;
      lim_hi     <= HI_RST;
      lim_lo     <= LO_RST;
    end else if (we) begin
      case (addr)
        2'd0: begin
          en         <= wdata[0];
          gain       <= wdata[OFF_GAIN +: cadj_pkg::GAIN_W];
          sync_sel   <= wdata[OFF_SYNC +: SYNC_W];
          first_sel  <= wdata[OFF_FIRST +: SEL_W];
          second_sel <= wdata[OFF_SECOND +: SEL_W];
        end
        2'd1: lim_hi <= wdata[ADJ_W-1:0];
        2'd2: lim_lo <= wdata[ADJ_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cadj_seq.sv
module cadj_seq #(
  parameter int N_PWM  = 4,
  parameter int N_FE   = 4,
  parameter int ERR_W  = 9,
  parameter int SYNC_W = 2,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [SYNC_W-1:0]       sync_sel,
  input  logic [SEL_W-1:0]        first_sel,
  input  logic [SEL_W-1:0]        second_sel,
  input  logic [N_PWM-1:0]        pwm_a,
  input  logic [N_FE-1:0]         fe_valid,
  input  logic [N_FE*ERR_W-1:0]   fe_err,
  output logic                    sync_hit,
  output logic                    cap1,
  output logic                    cap2,
  output logic signed [ERR_W-1:0] e1,
  output logic signed [ERR_W-1:0] e2,
  output cadj_pkg::seq_state_e    state
);
  import cadj_pkg::*;

  logic [N_PWM-1:0] pwm_q;
  logic [N_PWM-1:0] rise;
  seq_state_e       state_nx;

  assign rise     = pwm_a & ~pwm_q;
  assign sync_hit = en & rise[sync_sel];
  assign e2       = fe_err[second_sel*ERR_W +: ERR_W];
  assign cap1     = en && (state == SEQ_WAIT1) && !sync_hit && fe_valid[first_sel];
  assign cap2     = en && (state == SEQ_WAIT2) && !sync_hit && fe_valid[second_sel];

  always_comb begin
    state_nx = state;
    if (!en)           state_nx = SEQ_IDLE;
    else if (sync_hit) state_nx = SEQ_WAIT1;
    else if (cap1)     state_nx = SEQ_WAIT2;
    else if (cap2)     state_nx = SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= '0;
      state <= SEQ_IDLE;
      e1    <= '0;
    end else begin
      pwm_q <= pwm_a;
      state <= state_nx;
      if (cap1) e1 <= fe_err[first_sel*ERR_W +: ERR_W];
    end
  end
endmodule

// File: rtl/cadj_calc.sv
module cadj_calc #(
  parameter int ERR_W = 9,
  parameter int ADJ_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    cap2,
  input  logic signed [ERR_W-1:0] e1,
  input  logic signed [ERR_W-1:0] e2,
  input  logic [cadj_pkg::GAIN_W-1:0] gain,
  input  logic signed [ADJ_W-1:0] lim_hi,
  input  logic signed [ADJ_W-1:0] lim_lo,
  output logic signed [ADJ_W-1:0] adj_q,
  output logic                    done_q
);
  localparam int DIFF_W  = ERR_W + 1;
  localparam int SHIFT_W = DIFF_W + cadj_pkg::MAX_SHIFT;
  localparam int WIDE_W  = (SHIFT_W > ADJ_W) ? SHIFT_W : ADJ_W + 1;
  localparam logic signed [WIDE_W-1:0] MAXW = WIDE_W'((2 ** (ADJ_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] MINW = -MAXW - 1;

  // difference, shifted by the gain, saturated to the output width
  function automatic logic signed [ADJ_W-1:0] scale_sat(
    input logic signed [DIFF_W-1:0] d,
    input logic [cadj_pkg::GAIN_W-1:0] g
  );
    logic signed [WIDE_W-1:0] w;
    w = {{(WIDE_W-DIFF_W){d[DIFF_W-1]}}, d};
    w = w <<< g;
    if (w > MAXW)      return MAXW[ADJ_W-1:0];
    else if (w < MINW) return MINW[ADJ_W-1:0];
    else               return w[ADJ_W-1:0];
  endfunction

  // ceiling applied first, floor last
  function automatic logic signed [ADJ_W-1:0] clamp(
    input logic signed [ADJ_W-1:0] v,
    input logic signed [ADJ_W-1:0] hi,
    input logic signed [ADJ_W-1:0] lo
  );
    logic signed [ADJ_W-1:0] r;
    r = v;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  logic signed [DIFF_W-1:0] diff;
  logic signed [ADJ_W-1:0]  result;

  assign diff   = {e2[ERR_W-1], e2} - {e1[ERR_W-1], e1};
  assign result = clamp(scale_sat(diff, gain), lim_hi, lim_lo);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      adj_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap2;
      if (cap2) adj_q <= result;
    end
  end
endmodule

// File: rtl/cadj_apply.sv
module cadj_apply #(
  parameter int N_PWM  = 4,
  parameter int DUTY_W = 14,
  parameter int ADJ_W  = 12
) (
  input  logic [N_PWM*DUTY_W-1:0] duty_nom,
  input  logic [N_PWM-1:0]        adj_en,
  input  logic signed [ADJ_W-1:0] adj,
  output logic [N_PWM*DUTY_W-1:0] duty_out
);
  localparam int SUM_W = ((DUTY_W > ADJ_W) ? DUTY_W : ADJ_W) + 2;
  localparam logic signed [SUM_W-1:0] DMAX = SUM_W'((2 ** DUTY_W) - 1);

  for (genvar i = 0; i < N_PWM; i++) begin : g_ch
    logic [DUTY_W-1:0]       nom;
    logic signed [SUM_W-1:0] sum;
    logic [DUTY_W-1:0]       sat;

    assign nom = duty_nom[i*DUTY_W +: DUTY_W];
    assign sum = $signed({{(SUM_W-DUTY_W){1'b0}}, nom})
               + $signed({{(SUM_W-ADJ_W){adj[ADJ_W-1]}}, adj});

    always_comb begin
      if (sum < 0)         sat = '0;
      else if (sum > DMAX) sat = DMAX[DUTY_W-1:0];
      else                 sat = sum[DUTY_W-1:0];
    end

    assign duty_out[i*DUTY_W +: DUTY_W] = adj_en[i] ? sat : nom;
  end
endmodule

// File: rtl/cyc_adj_top.sv
module cyc_adj_top #(
  parameter int N_PWM  = 4,
  parameter int N_FE   = 4,
  parameter int ERR_W  = 9,
  parameter int ADJ_W  = 12,
  parameter int DUTY_W = 14,
  localparam int SYNC_W = $clog2(N_PWM),
  localparam int SEL_W  = $clog2(N_FE),
  localparam int CTRL_W = 1 + cadj_pkg::GAIN_W + SYNC_W + 2 * SEL_W,
  localparam int REG_W  = (ADJ_W > CTRL_W) ? ADJ_W : CTRL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [1:0]              reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  input  logic [N_PWM-1:0]        pwm_a,
  input  logic [N_FE-1:0]         fe_valid,
  input  logic [N_FE*ERR_W-1:0]   fe_err,
  input  logic [N_PWM*DUTY_W-1:0] duty_nom,
  input  logic [N_PWM-1:0]        duty_adj_en,
  output logic [ADJ_W-1:0]        adj_out,
  output logic                    adj_done,
  output logic [N_PWM*DUTY_W-1:0] duty_out
);
  import cadj_pkg::*;

  logic                    en_q;
  logic [GAIN_W-1:0]       gain_q;
  logic [SYNC_W-1:0]       sync_sel_q;
  logic [SEL_W-1:0]        first_sel_q;
  logic [SEL_W-1:0]        second_sel_q;
  logic signed [ADJ_W-1:0] lim_hi_q;
  logic signed [ADJ_W-1:0] lim_lo_q;
  logic                    sync_hit;
  logic                    cap1;
  logic                    cap2;
  logic signed [ERR_W-1:0] e1;
  logic signed [ERR_W-1:0] e2;
  seq_state_e              seq_state;
  logic                    st_idle;
  logic signed [ADJ_W-1:0] adj_q;
  logic                    done_q;
  logic signed [ADJ_W-1:0] adj_pub;

  cadj_regs #(.SYNC_W(SYNC_W), .SEL_W(SEL_W), .ADJ_W(ADJ_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en(en_q), .gain(gain_q), .sync_sel(sync_sel_q), .first_sel(first_sel_q),
    .second_sel(second_sel_q), .lim_hi(lim_hi_q), .lim_lo(lim_lo_q)
  );

  cadj_seq #(.N_PWM(N_PWM), .N_FE(N_FE), .ERR_W(ERR_W), .SYNC_W(SYNC_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sync_sel(sync_sel_q), .first_sel(first_sel_q),
    .second_sel(second_sel_q), .pwm_a(pwm_a), .fe_valid(fe_valid), .fe_err(fe_err),
    .sync_hit(sync_hit), .cap1(cap1), .cap2(cap2), .e1(e1), .e2(e2), .state(seq_state)
  );

  cadj_calc #(.ERR_W(ERR_W), .ADJ_W(ADJ_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cap2(cap2), .e1(e1), .e2(e2),
    .gain(gain_q), .lim_hi(lim_hi_q), .lim_lo(lim_lo_q), .adj_q(adj_q), .done_q(done_q)
  );

  assign st_idle  = (seq_state == SEQ_IDLE);
  assign adj_pub  = en_q ? adj_q : '0;
  assign adj_out  = adj_pub;
  assign adj_done = done_q & en_q;

  cadj_apply #(.N_PWM(N_PWM), .DUTY_W(DUTY_W), .ADJ_W(ADJ_W)) u_apply (
    .duty_nom(duty_nom), .adj_en(duty_adj_en), .adj(adj_pub), .duty_out(duty_out)
  );
endmodule

// File: rtl/cadj_checker.sv
module cadj_checker #(
  parameter int ADJ_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en_q,
  input logic                    sync_hit,
  input logic                    cap1,
  input logic                    cap2,
  input logic                    st_idle,
  input logic signed [ADJ_W-1:0] adj_out,
  input logic                    adj_done,
  input logic signed [ADJ_W-1:0] lim_hi,
  input logic signed [ADJ_W-1:0] lim_lo
);
  assert_idle_without_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && !sync_hit |=> st_idle);

  assert_one_capture_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap1 |-> !cap2);

  assert_clamped_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done && ($past(lim_lo) <= $past(lim_hi)) |->
      (adj_out <= $past(lim_hi)) && (adj_out >= $past(lim_lo)));

  assert_done_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap2 |=> (adj_done || !en_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done |=> !adj_done);

  assert_hold_between_updates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && $past(en_q) && !adj_done |-> adj_out == $past(adj_out));

  assert_off_output_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (adj_out == '0) && !adj_done);

  assert_off_goes_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> st_idle);
endmodule

bind cyc_adj_top cadj_checker #(.ADJ_W(ADJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .sync_hit(sync_hit), .cap1(cap1),
  .cap2(cap2), .st_idle(st_idle), .adj_out(adj_pub), .adj_done(adj_done),
  .lim_hi(lim_hi_q), .lim_lo(lim_lo_q)
);

// File: tb/sim_cyc_adj_top.sv
module sim_cyc_adj_top;
  localparam int N_PWM = 4, N_FE = 4, ERR_W = 9, ADJ_W = 12, DUTY_W = 14, REG_W = 12;
  localparam int AMAX = 2047, AMIN = -2048, DMAX = 16383;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [N_PWM-1:0] pwm_a = '0;
  logic [N_FE-1:0] fe_valid = '0;
  logic [N_FE*ERR_W-1:0] fe_err = '0;
  logic [N_PWM*DUTY_W-1:0] duty_nom;
  logic [N_PWM-1:0] duty_adj_en = 4'b0111;
  logic [ADJ_W-1:0] adj_out;
  logic adj_done;
  logic [N_PWM*DUTY_W-1:0] duty_out;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cyc_adj_top u0 (.*);

  // behavioural reference model
  int m_en, m_gain, m_sync, m_first, m_second, m_hi, m_lo;
  int m_state, m_e1, m_adj, m_done;
  logic [N_PWM-1:0] m_prev;

  function automatic int fe_val(int f);
    logic signed [ERR_W-1:0] v;
    v = fe_err[f*ERR_W +: ERR_W];
    return int'(v);
  endfunction

  function automatic int s12(logic [REG_W-1:0] v);
    logic signed [ADJ_W-1:0] s;
    s = v[ADJ_W-1:0];
    return int'(s);
  endfunction

  function automatic int ref_result(int a, int b);
    int r;
    r = (b - a) * (2 ** m_gain);
    if (r > AMAX) r = AMAX;
    if (r < AMIN) r = AMIN;
    if (r > m_hi) r = m_hi;
    if (r < m_lo) r = m_lo;
    return r;
  endfunction

  task automatic model_step();
    bit hit;
    if (!rst_n) begin
      m_en = 0; m_gain = 0; m_sync = 0; m_first = 0; m_second = 0;
      m_hi = AMAX; m_lo = AMIN; m_state = 0; m_e1 = 0; m_adj = 0; m_done = 0;
      m_prev = '0;
      return;
    end
    hit = (m_en != 0) && pwm_a[m_sync] && !m_prev[m_sync];
    if (m_en == 0) begin
      m_state = 0; m_adj = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (hit) m_state = 1;
      else if (m_state == 1 && fe_valid[m_first]) begin
        m_e1 = fe_val(m_first); m_state = 2;
      end else if (m_state == 2 && fe_valid[m_second]) begin
        m_adj = ref_result(m_e1, fe_val(m_second)); m_done = 1; m_state = 0;
      end
    end
    if (reg_we) begin
      if (reg_addr == 0) begin
        m_en = int'(reg_wdata[0]); m_gain = int'(reg_wdata[3:1]);
        m_sync = int'(reg_wdata[5:4]); m_first = int'(reg_wdata[7:6]);
        m_second = int'(reg_wdata[9:8]);
      end else if (reg_addr == 1) m_hi = s12(reg_wdata);
      else if (reg_addr == 2) m_lo = s12(reg_wdata);
    end
    m_prev = pwm_a;
  endtask

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ea, d;
    logic signed [ADJ_W-1:0] a;
    a = adj_out;
    ea = (m_en != 0) ? m_adj : 0;
    chk(int'(a), ea, {cur_req, " adj_out"});
    chk(int'(adj_done), (m_en != 0) ? m_done : 0, {cur_req, " adj_done"});
    for (int i = 0; i < N_PWM; i++) begin
      d = int'(duty_nom[i*DUTY_W +: DUTY_W]);
      if (duty_adj_en[i]) begin
        d = d + ea;
        if (d < 0) d = 0;
        if (d > DMAX) d = DMAX;
      end
      chk(int'(duty_out[i*DUTY_W +: DUTY_W]), d, {cur_req, " R11 duty_out"});
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    compare();
  end

  // stimulus helpers (all drive at the falling edge)
  task automatic wr(int a, int v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = REG_W'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int ctrl(int en, int g, int sy, int f1, int f2);
    return en | (g << 1) | (sy << 4) | (f1 << 6) | (f2 << 8);
  endfunction

  task automatic edge_on(int ch);
    @(negedge clk); pwm_a[ch] = 1'b1;
    @(negedge clk); pwm_a[ch] = 1'b0;
  endtask

  task automatic sample(int f, int e);
    @(negedge clk);
    fe_valid[f] = 1'b1; fe_err[f*ERR_W +: ERR_W] = ERR_W'(e);
    @(negedge clk);
    fe_valid[f] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sadj();
    logic signed [ADJ_W-1:0] a;
    a = adj_out;
    return int'(a);
  endfunction

  initial begin
    duty_nom = {14'd8000, 14'd1000, 14'd5, 14'd16380};
    idle(3);
    chk(sadj(), 0, "R1 reset adj_out");
    chk(int'(adj_done), 0, "R1 reset adj_done");
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    wr(3, 12'hFFF);
    wr(0, ctrl(1, 0, 1, 0, 2));
    cur_req = "R6";
    edge_on(1); sample(0, 10); sample(2, 11);
    chk(sadj(), 1, "R6 gain0 one LSB");
    chk(int'(adj_done), 1, "R8 done pulse");
    idle(1);
    chk(int'(adj_done), 0, "R8 done single");

    cur_req = "R3";
    edge_on(0); edge_on(2); sample(0, 50); sample(2, 90); idle(2);
    chk(sadj(), 1, "R3 unselected edge ignored");

    cur_req = "R4";
    edge_on(1); sample(3, 100); sample(2, 7); sample(0, -5); sample(2, 20);
    chk(sadj(), 25, "R4 selected front ends");
    @(negedge clk); pwm_a[1] = 1'b1; fe_valid[0] = 1'b1; fe_err[0 +: ERR_W] = 9'd40;
    @(negedge clk); pwm_a[1] = 1'b0; fe_valid[0] = 1'b0;
    sample(0, 2); sample(2, 6);
    chk(sadj(), 4, "R4 sample in sync cycle ignored");

    cur_req = "R5";
    wr(0, ctrl(1, 0, 1, 0, 0));
    edge_on(1); sample(0, 3); idle(1); sample(0, 8);
    chk(sadj(), 5, "R5 same front end two cycles");

    cur_req = "R6";
    wr(0, ctrl(1, 3, 1, 0, 2));
    edge_on(1); sample(0, 7); sample(2, 0);
    chk(sadj(), -56, "R6 gain3 negative");
    wr(0, ctrl(1, 7, 1, 0, 2));
    edge_on(1); sample(0, -256); sample(2, 255);
    chk(sadj(), AMAX, "R6 R1 saturate to full range");
    edge_on(1); sample(0, 255); sample(2, -256);
    chk(sadj(), AMIN, "R6 R1 saturate negative");

    cur_req = "R7";
    wr(1, 100); wr(2, -30);
    edge_on(1); sample(0, 0); sample(2, 200);
    chk(sadj(), 100, "R7 ceiling");
    chk(int'(duty_out[0 +: DUTY_W]), DMAX, "R11 saturate high");
    edge_on(1); sample(0, 200); sample(2, 0);
    chk(sadj(), -30, "R7 floor");
    chk(int'(duty_out[DUTY_W +: DUTY_W]), 0, "R11 saturate low");
    chk(int'(duty_out[3*DUTY_W +: DUTY_W]), 8000, "R11 opted-out channel");
    wr(1, 5); wr(2, 9);
    edge_on(1); sample(0, 0); sample(2, -1);
    chk(sadj(), 9, "R7 floor wins over ceiling");

    cur_req = "R9";
    wr(1, AMAX); wr(2, AMIN); wr(0, ctrl(1, 0, 1, 0, 2));
    edge_on(1); sample(0, 100); edge_on(1); sample(2, 77); sample(0, 10); sample(2, 12);
    chk(sadj(), 2, "R9 resync discards first");

    cur_req = "R8";
    idle(5);
    chk(sadj(), 2, "R8 hold");

    cur_req = "R10";
    edge_on(1); sample(0, 1);
    wr(0, ctrl(0, 0, 1, 0, 2));
    chk(sadj(), 0, "R10 disabled zero");
    sample(2, 50); edge_on(1); sample(0, 1); sample(2, 9);
    chk(int'(adj_done), 0, "R10 no done while off");
    wr(0, ctrl(1, 0, 1, 0, 2));
    sample(2, 40); idle(2);
    chk(sadj(), 0, "R10 zero after re-enable");
    edge_on(1); sample(0, 1); sample(2, 4);
    chk(sadj(), 3, "R10 measures after re-enable");

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule